// File: doc/BRIEF.md
# Replica-Delay Adaptive Supply Controller

This block closes a digital loop around the supply of a signal-processing load. The aim is the lowest supply voltage at which that load still keeps pace with its demanded sample rate. Two external signals arrive asynchronously. The first is a reference clock that toggles once per input sample. The second comes from a ring oscillator built from a copy of the load's slowest path plus some spare inverter delay, and it runs from the regulated rail. Both are synchronised and their rising edges are counted over a window that spans a fixed number of reference periods.

At the close of each window the block steps a digital voltage code by at most one. If the replica is too slow, the code rises. If the replica is faster than needed by more than a margin, the code falls. Inside that band the code holds. The code sets the duty of a pulse-width modulated drive for an external buck stage.

A startup tracker watches for a run of windows in which the code does not move. It then raises a latched signal that moves the controller's own supply from the backup source over to the regulated rail.

Top module: `rdsc_top`

## Requirements
- R1: While reset is held, the voltage code equals CODE_RST (default 48), the supply handoff output is 0 and the window strobe is 0.
- R2: The window strobe is high for exactly one clock cycle after every WIN_REFS (default 4) synchronised rising edges of the reference input, and at no other time.
- R3: At the close of a window, if the count of replica rising edges is below WIN_REFS, the code rises by one.
- R4: At the close of a window, if the replica edge count is above WIN_REFS + MARGIN (default 6), the code falls by one.
- R5: If the replica edge count lies between WIN_REFS and WIN_REFS + MARGIN inclusive, the code is unchanged.
- R6: An increase is suppressed when the code already equals or exceeds the code_max input, so the code stays where it is.
- R7: A decrease is suppressed when the code already equals or is below the code_min input, so the code stays where it is.
- R8: The code changes only in the cycle the window strobe is high, and it changes by at most one per window.
- R9: The PWM output is high for exactly code cycles out of every PWM_PERIOD (default 64) clock cycles. A code of 0 keeps it low and a code of PWM_PERIOD or more keeps it high.
- R10: The handoff output rises in the strobe cycle that ends the STABLE_WINS-th (default 3) consecutive window without a code change. It then stays high until reset. A suppressed step counts as no change.
- R11: Any window that changes the code restarts the run of unchanged windows from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk_in | input | 1 | Sample-rate reference, asynchronous |
| replica_osc_in | input | 1 | Replica ring oscillator output, asynchronous |
| code_min | input | CODE_W | Lowest code a decrease may reach |
| code_max | input | CODE_W | Highest code an increase may reach |
| vcode | output | CODE_W | Current voltage code |
| pwm_out | output | 1 | Buck drive, duty = vcode / PWM_PERIOD |
| win_end | output | 1 | One-cycle strobe marking a window close and code update |
| use_main_supply | output | 1 | Latched handoff to the regulated rail |

## Verification
The assertions assume a few things about the inputs. The code limits are held steady and satisfy code_min <= code_max <= PWM_PERIOD. Reference edges are spaced at least two controller cycles apart, so two window closes never fall in adjacent cycles. The stimulus keeps within these assumptions. It changes the limits only between window closes and keeps CODE_RST inside them. It drives a reference with a 40-cycle period, and it places every replica burst well clear of the reference edge that closes the window, so the edge count per window is exact.

// File: rtl/rdsc_pkg.sv
package rdsc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;

  typedef enum logic {
    SUP_BACKUP = 1'b0,
    SUP_MAIN   = 1'b1
  } supply_src_e;
endpackage

// File: rtl/rdsc_edge_sync.sv
module rdsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] shift_q;
  logic [STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rise_pulse = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/rdsc_freq_window.sv
module rdsc_freq_window #(
  parameter int WIN_REFS = 4,
  parameter int OSC_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             osc_rise,
  output logic             win_done,
  output logic [OSC_W-1:0] osc_total
);
  localparam int REF_W = (WIN_REFS > 2) ? $clog2(WIN_REFS) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(WIN_REFS - 1);
  localparam logic [OSC_W-1:0] OSC_SAT  = {OSC_W{1'b1}};

  logic [REF_W-1:0] ref_cnt_q, ref_cnt_d;
  logic [OSC_W-1:0] osc_cnt_q, osc_cnt_d;
  logic             cnt_en;

  always_comb begin
    win_done  = ref_rise && (ref_cnt_q == REF_LAST);
    osc_total = (osc_rise && (osc_cnt_q != OSC_SAT)) ? osc_cnt_q + 1'b1 : osc_cnt_q;
    cnt_en    = ref_rise | osc_rise;
    if (win_done) begin
      ref_cnt_d = '0;
      osc_cnt_d = '0;
    end else begin
      ref_cnt_d = ref_rise ? ref_cnt_q + 1'b1 : ref_cnt_q;
      osc_cnt_d = osc_total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      osc_cnt_q <= '0;
    end else if (cnt_en) begin
      ref_cnt_q <= ref_cnt_d;
      osc_cnt_q <= osc_cnt_d;
    end
  end
endmodule

// File: rtl/rdsc_code_step.sv
module rdsc_code_step
  import rdsc_pkg::*;
#(
  parameter int WIN_REFS = 4,
  parameter int MARGIN   = 2,
  parameter int OSC_W    = 12,
  parameter int CODE_W   = 7,
  parameter int CODE_RST = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_done,
  input  logic [OSC_W-1:0]  osc_total,
  input  logic [CODE_W-1:0] code_min,
  input  logic [CODE_W-1:0] code_max,
  output logic [CODE_W-1:0] code_q,
  output logic              code_moved,
  output logic              strobe_q
);
  localparam logic [OSC_W-1:0] LOW_LIM  = OSC_W'(WIN_REFS);
  localparam logic [OSC_W-1:0] HIGH_LIM = OSC_W'(WIN_REFS + MARGIN);

  step_dir_e         dir;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    if (osc_total < LOW_LIM)       dir = STEP_UP;
    else if (osc_total > HIGH_LIM) dir = STEP_DOWN;
    else                           dir = STEP_HOLD;

    code_d = code_q;
    unique case (dir)
      STEP_UP:   if (code_q < code_max) code_d = code_q + 1'b1;
      STEP_DOWN: if (code_q > code_min) code_d = code_q - 1'b1;
      default:   code_d = code_q;
    endcase
    code_moved = win_done && (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= CODE_W'(CODE_RST);
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= win_done;
      if (win_done) code_q <= code_d;
    end
  end
endmodule

// File: rtl/rdsc_boot_fsm.sv
module rdsc_boot_fsm
  import rdsc_pkg::*;
#(
  parameter int STABLE_WINS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  input  logic code_moved,
  output logic use_main
);
  localparam int RUN_W = $clog2(STABLE_WINS + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_WINS - 1);

  supply_src_e      state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (win_done) begin
      if (code_moved) begin
        run_d = '0;
      end else begin
        if (run_q < RUN_W'(STABLE_WINS)) run_d = run_q + 1'b1;
        if (run_q == RUN_LAST)           state_d = SUP_MAIN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_BACKUP;
      run_q   <= '0;
    end else if (win_done) begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign use_main = (state_q == SUP_MAIN);
endmodule

// File: rtl/rdsc_pwm.sv
module rdsc_pwm #(
  parameter int PWM_PERIOD = 64,
  parameter int CODE_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] duty_code,
  output logic              pwm_q
);
  localparam int PW = $clog2(PWM_PERIOD);
  localparam logic [PW-1:0] PHASE_LAST = PW'(PWM_PERIOD - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          pwm_d;

  always_comb begin
    phase_d = (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
    pwm_d   = (CODE_W'(phase_q) < duty_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pwm_q   <= pwm_d;
    end
  end
endmodule

// File: rtl/rdsc_top.sv
module rdsc_top #(
  parameter int WIN_REFS    = 4,
  parameter int MARGIN      = 2,
  parameter int STABLE_WINS = 3,
  parameter int PWM_PERIOD  = 64,
  parameter int CODE_RST    = 48,
  parameter int OSC_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = $clog2(PWM_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk_in,
  input  logic              replica_osc_in,
  input  logic [CODE_W-1:0] code_min,
  input  logic [CODE_W-1:0] code_max,
  output logic [CODE_W-1:0] vcode,
  output logic              pwm_out,
  output logic              win_end,
  output logic              use_main_supply
);
  localparam int N_IN = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [N_IN-1:0]  raw_in;
  logic [N_IN-1:0]  rise;
  logic             win_done;
  logic [OSC_W-1:0] osc_total;
  logic             code_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_in = {replica_osc_in, ref_clk_in};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    rdsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .async_in   (raw_in[gi]),
      .rise_pulse (rise[gi])
    );
  end

  rdsc_freq_window #(.WIN_REFS(WIN_REFS), .OSC_W(OSC_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ref_rise  (rise[0]),
    .osc_rise  (rise[1]),
    .win_done  (win_done),
    .osc_total (osc_total)
  );

  rdsc_code_step #(
    .WIN_REFS(WIN_REFS), .MARGIN(MARGIN), .OSC_W(OSC_W),
    .CODE_W(CODE_W), .CODE_RST(CODE_RST)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .win_done   (win_done),
    .osc_total  (osc_total),
    .code_min   (code_min),
    .code_max   (code_max),
    .code_q     (vcode),
    .code_moved (code_moved),
    .strobe_q   (win_end)
  );

  rdsc_boot_fsm #(.STABLE_WINS(STABLE_WINS)) u_boot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .win_done   (win_done),
    .code_moved (code_moved),
    .use_main   (use_main_supply)
  );

  rdsc_pwm #(.PWM_PERIOD(PWM_PERIOD), .CODE_W(CODE_W)) u_pwm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .duty_code (vcode),
    .pwm_q     (pwm_out)
  );
endmodule

// File: rtl/rdsc_checker.sv
module rdsc_checker #(
  parameter int PWM_PERIOD = 64,
  parameter int CODE_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code_min,
  input logic [CODE_W-1:0] code_max,
  input logic [CODE_W-1:0] vcode,
  input logic              pwm_out,
  input logic              win_end,
  input logic              use_main_supply
);
  localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(PWM_PERIOD);

  assert_win_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !win_end);

  assert_code_moves_at_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcode) |-> win_end);

  assert_step_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> (vcode == $past(vcode) || vcode == $past(vcode) + ONE || vcode + ONE == $past(vcode)));

  assert_code_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && vcode > $past(vcode)) |-> vcode <= code_max);

  assert_code_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && vcode < $past(vcode)) |-> vcode >= code_min);

  assert_pwm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode == '0 && $stable(vcode)) |=> !pwm_out);

  assert_pwm_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vcode >= FULL && $stable(vcode)) |=> pwm_out);

  assert_handoff_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    use_main_supply |=> use_main_supply);

  assert_handoff_at_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_main_supply) |-> win_end);
endmodule

bind rdsc_top rdsc_checker #(.PWM_PERIOD(PWM_PERIOD), .CODE_W(CODE_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .code_min        (code_min),
  .code_max        (code_max),
  .vcode           (vcode),
  .pwm_out         (pwm_out),
  .win_end         (win_end),
  .use_main_supply (use_main_supply)
);

// File: tb/rdsc_top_tb.sv
module rdsc_top_tb;
  localparam int WIN_REFS    = 4;
  localparam int MARGIN      = 2;
  localparam int STABLE_WINS = 3;
  localparam int PWM_PERIOD  = 64;
  localparam int CODE_RST    = 48;
  localparam int CODE_W      = $clog2(PWM_PERIOD + 1);
  localparam int REF_HALF    = 20;
  localparam int WIN_CYC     = 2 * REF_HALF * WIN_REFS;

  typedef struct {
    int    code;
    bit    sw;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ref_clk_in;
  logic              replica_osc_in;
  logic [CODE_W-1:0] code_min;
  logic [CODE_W-1:0] code_max;
  logic [CODE_W-1:0] vcode;
  logic              pwm_out;
  logic              win_end;
  logic              use_main_supply;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   windows_seen = 0;
  bit   finished = 0;
  int   m_code = CODE_RST;
  int   m_run  = 0;
  bit   m_sw   = 0;

  always #4 clk = ~clk;

  rdsc_top #(
    .WIN_REFS(WIN_REFS), .MARGIN(MARGIN), .STABLE_WINS(STABLE_WINS),
    .PWM_PERIOD(PWM_PERIOD), .CODE_RST(CODE_RST)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .replica_osc_in(replica_osc_in),
    .code_min(code_min), .code_max(code_max), .vcode(vcode), .pwm_out(pwm_out),
    .win_end(win_end), .use_main_supply(use_main_supply)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: model the expected code and handoff, queue them, then drive one window
  task automatic run_window(input int m, input int mn, input int mx, input string tag);
    exp_t e;
    int   nc;
    code_min = CODE_W'(mn);
    code_max = CODE_W'(mx);
    nc = m_code;
    if (m < WIN_REFS)               nc = (m_code < mx) ? m_code + 1 : m_code;
    else if (m > WIN_REFS + MARGIN) nc = (m_code > mn) ? m_code - 1 : m_code;
    if (nc == m_code) begin
      m_run++;
      if (m_run >= STABLE_WINS) m_sw = 1;
    end else begin
      m_run = 0;
    end
    m_code = nc;
    e.code = nc; e.sw = m_sw; e.tag = tag;
    exp_q.push_back(e);
    for (int t = 0; t < WIN_CYC; t++) begin
      ref_clk_in     = ((t % (2 * REF_HALF)) >= REF_HALF);
      replica_osc_in = (t >= 30 && t < 30 + 4 * m) ? (((t - 30) % 4) < 2) : 1'b0;
      @(negedge clk);
    end
  endtask

  // monitor: pop the expected item on each strobe, then measure the PWM duty
  initial begin
    exp_t e;
    int   hi;
    forever begin
      @(negedge clk);
      if (win_end === 1'b1) begin
        windows_seen++;
        if (exp_q.size() == 0) begin
          check(0, "R2", "strobe with no window pending", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(vcode == CODE_W'(e.code), e.tag, "vcode", int'(vcode), e.code);
          check(use_main_supply == e.sw, "R10", "handoff", int'(use_main_supply), int'(e.sw));
          @(negedge clk);
          check(win_end == 1'b0, "R2", "strobe width", int'(win_end), 0);
          hi = 0;
          for (int k = 0; k < PWM_PERIOD; k++) begin
            @(negedge clk);
            hi += int'(pwm_out);
          end
          check(hi == e.code, "R9", "pwm high cycles", hi, e.code);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    int hi;
    rst_n = 1'b0;
    ref_clk_in = 1'b0;
    replica_osc_in = 1'b0;
    code_min = CODE_W'(40);
    code_max = CODE_W'(50);
    repeat (3) @(negedge clk);
    check(vcode == CODE_W'(CODE_RST), "R1", "reset code", int'(vcode), CODE_RST);
    check(use_main_supply == 1'b0, "R1", "reset handoff", int'(use_main_supply), 0);
    check(win_end == 1'b0, "R1", "reset strobe", int'(win_end), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    hi = 0;
    for (int k = 0; k < PWM_PERIOD; k++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    check(hi == CODE_RST, "R9", "pwm after reset", hi, CODE_RST);

    run_window(2,  40, 50, "R3");   // slow replica: 48 -> 49
    run_window(5,  40, 50, "R5");   // in band: hold
    run_window(6,  40, 50, "R5");   // upper band edge: hold
    run_window(3,  40, 50, "R11");  // up to 50, run restarts
    run_window(7,  40, 50, "R4");   // just above band: 49
    run_window(4,  40, 50, "R5");   // lower band edge: hold
    run_window(0,  40, 50, "R3");   // no edges: 50
    run_window(1,  40, 50, "R6");   // at ceiling: stays 50
    run_window(12, 40, 50, "R4");   // 49
    run_window(9,  47, 50, "R4");   // 48
    run_window(9,  47, 50, "R4");   // 47
    run_window(9,  47, 50, "R7");   // at floor: stays 47
    run_window(20, 47, 50, "R7");   // still 47
    run_window(8,  47, 50, "R10");  // third unchanged: handoff
    run_window(2,  47, 50, "R10");  // 48, handoff stays
    run_window(5,  47, 50, "R8");   // hold
    ref_clk_in = 1'b0;
    replica_osc_in = 1'b0;
    repeat (120) @(negedge clk);
    check(exp_q.size() == 0, "R2", "windows left unclosed", exp_q.size(), 0);
    check(windows_seen == 16, "R2", "strobe count", windows_seen, 16);
    finish_run();
  end
endmodule